// File: doc/BRIEF.md
# DS3 PLCP Frame Generator

This block wraps a stream of 53-byte ATM cells into the 12-row DS3 Physical Layer Convergence Protocol frame. Each row starts with the two framing bytes, a row identifier and one path overhead byte, and then carries exactly one cell. The result is a byte stream with a valid strobe, ready to be handed to a DS3 mapper.

Cells come in on a byte bus with a start-of-cell flag and a valid/ready handshake. While the generator is sending the four header bytes of a row, it holds ready low. During the cell part of a row, output follows input directly: a missing input byte gives a cycle with no output. The user channel byte, the path status byte and the cycle/stuff byte are taken from static register inputs. The parity byte is computed internally over the previous frame. A one-cycle request corrupts the next parity byte, so that a far end's error counting can be tested.

Top module: `plcp_frame_gen`

## Requirements
- R1: Every row begins with the byte 0xF6, followed at once by 0x28.
- R2: The third byte of row r (r = 0..11) is the row identifier. The values are 0x2C, 0x29, 0x25, 0x20, 0x1C, 0x19, 0x15, 0x10, 0x0D, 0x08, 0x04, 0x01, in row order.
- R3: The fourth byte of each row is its overhead byte, in this order:
  - rows 0–5: growth bytes, sent as 0x00;
  - row 6: `userByte`;
  - row 7: the parity byte;
  - row 8: the path status byte;
  - rows 9 and 10: management bytes, sent as 0x00;
  - row 11: `cycleByte`.
- R4: The path status byte equals `statusByte` with register bits 2..0 forced to 0 (these are serial bits 6–8, since serial bit 1 is register bit 7).
- R5: The parity byte is the bitwise XOR of every byte sent in the previous frame, excluding the two framing bytes of each row. It is sent exactly as it went out, including any inserted error. In the first frame after reset it is 0x00.
- R6: A one-cycle `errInsert` pulse inverts register bit 0 of the next parity byte sent, and of no later one. A pulse in the same cycle as a parity byte is emitted applies to the following frame.
- R7: `cellReady` is low while the next output byte is one of a row's four header bytes, and high while it is a cell byte.
- R8: The cell bytes of a row are the 53 accepted input bytes, in arrival order and unchanged.
- R9: An input byte offered at the first cell position without `cellSoc` set is consumed and discarded. It produces no output.
- R10: When `cellReady` is high and `cellValid` is low, no byte is output in the following cycle.
- R11: During reset, `outValid` and `cellReady` are low. The first byte after reset is the first byte of row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellData | input | 8 | Cell byte, register bit 7 sent first |
| cellSoc | input | 1 | Marks the first byte of a cell |
| cellValid | input | 1 | Cell byte offered |
| cellReady | output | 1 | Generator accepts a cell byte this cycle |
| userByte | input | 8 | User channel byte |
| statusByte | input | 8 | Path status byte (bits 2..0 not used) |
| cycleByte | input | 8 | Cycle/stuff counter byte |
| errInsert | input | 1 | Request to corrupt the next parity byte |
| outData | output | 8 | Frame byte |
| outValid | output | 1 | `outData` holds a new byte |

## Verification
Each output byte is registered. It appears after the same clock edge that accepts its cell byte or that produces its header byte. The bench therefore samples just after each rising edge and compares the byte against its own frame model, indexed by the count of valid bytes received. `cellReady` depends only on the row position, so the bench checks it at the same sample point against the position of the next expected byte. The effect of a gap (R10) is checked one edge after the cycle in which valid was low. The parity byte is checked one frame after the bytes it covers, and the inserted error in the frame after the pulse.

// File: rtl/plcp_gen_pkg.sv
package plcp_gen_pkg;
  localparam int ROWS      = 12;
  localparam int HDR_BYTES = 4;
  localparam int ROW_W     = 4;
  localparam int F1_ROW    = 6;
  localparam int B1_ROW    = 7;
  localparam int G1_ROW    = 8;
  localparam int C1_ROW    = 11;
  localparam logic [7:0] SYNC1 = 8'hF6;
  localparam logic [7:0] SYNC2 = 8'h28;

  typedef enum logic [2:0] {FLD_SYNC1, FLD_SYNC2, FLD_ROWID, FLD_OVH, FLD_CELL} field_e;

  typedef struct packed {
    field_e           field;
    logic [ROW_W-1:0] row;
    logic             emit;
    logic             cellFirst;
    logic             frameEnd;
  } ctl_t;

  function automatic logic [7:0] rowId(input logic [ROW_W-1:0] r);
    case (r)
      4'd0:    rowId = 8'h2C;
      4'd1:    rowId = 8'h29;
      4'd2:    rowId = 8'h25;
      4'd3:    rowId = 8'h20;
      4'd4:    rowId = 8'h1C;
      4'd5:    rowId = 8'h19;
      4'd6:    rowId = 8'h15;
      4'd7:    rowId = 8'h10;
      4'd8:    rowId = 8'h0D;
      4'd9:    rowId = 8'h08;
      4'd10:   rowId = 8'h04;
      default: rowId = 8'h01;
    endcase
  endfunction
endpackage

// File: rtl/plcp_gen_ctrl.sv
module plcp_gen_ctrl
  import plcp_gen_pkg::*;
#(
  parameter int CELL_BYTES = 53
) (
  input  logic clk,
  input  logic rstN,
  input  logic cellValid,
  input  logic cellSoc,
  output logic cellReady,
  output ctl_t ctl
);
  localparam int ROW_BYTES = CELL_BYTES + HDR_BYTES;
  localparam int COL_W     = $clog2(ROW_BYTES);
  localparam logic [COL_W-1:0] LAST_COL  = COL_W'(ROW_BYTES - 1);
  localparam logic [COL_W-1:0] FIRST_CEL = COL_W'(HDR_BYTES);
  localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(ROWS - 1);

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic inCell, firstCell, advance, lastCol;

  assign inCell    = (col >= FIRST_CEL);
  assign firstCell = (col == FIRST_CEL);
  assign lastCol   = (col == LAST_COL);
  assign advance   = !inCell || (cellValid && (!firstCell || cellSoc));
  assign cellReady = rstN && inCell;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      col <= '0;
      row <= '0;
    end else if (advance) begin
      if (lastCol) begin
        col <= '0;
        row <= (row == LAST_ROW) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.row       = row;
    ctl.emit      = rstN && advance;
    ctl.cellFirst = firstCell;
    ctl.frameEnd  = rstN && advance && lastCol && (row == LAST_ROW);
    case (col)
      COL_W'(0): ctl.field = FLD_SYNC1;
      COL_W'(1): ctl.field = FLD_SYNC2;
      COL_W'(2): ctl.field = FLD_ROWID;
      COL_W'(3): ctl.field = FLD_OVH;
      default:   ctl.field = FLD_CELL;
    endcase
  end
endmodule

// File: rtl/plcp_gen_dpath.sv
module plcp_gen_dpath
  import plcp_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctl_t       ctl,
  input  logic [7:0] cellData,
  input  logic [7:0] userByte,
  input  logic [7:0] statusByte,
  input  logic [7:0] cycleByte,
  input  logic       errInsert,
  output logic [7:0] outData,
  output logic       outValid,
  output logic       errPend
);
  logic [7:0] bipAcc, bipPrev, ovhByte, byteNow;
  logic       parityNow, coveredNow;

  assign parityNow  = ctl.emit && (ctl.field == FLD_OVH) && (ctl.row == ROW_W'(B1_ROW));
  assign coveredNow = ctl.emit && (ctl.field != FLD_SYNC1) && (ctl.field != FLD_SYNC2);

  always_comb begin
    case (ctl.row)
      ROW_W'(F1_ROW): ovhByte = userByte;
      ROW_W'(B1_ROW): ovhByte = bipPrev ^ {7'b0, errPend};
      ROW_W'(G1_ROW): ovhByte = {statusByte[7:3], 3'b000};
      ROW_W'(C1_ROW): ovhByte = cycleByte;
      default:        ovhByte = 8'h00;
    endcase
    case (ctl.field)
      FLD_SYNC1: byteNow = SYNC1;
      FLD_SYNC2: byteNow = SYNC2;
      FLD_ROWID: byteNow = rowId(ctl.row);
      FLD_OVH:   byteNow = ovhByte;
      default:   byteNow = cellData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= '0;
      outValid <= 1'b0;
      bipAcc   <= '0;
      bipPrev  <= '0;
      errPend  <= 1'b0;
    end else begin
      outValid <= ctl.emit;
      if (ctl.emit) outData <= byteNow;
      if (ctl.frameEnd) begin
        bipPrev <= bipAcc ^ byteNow;
        bipAcc  <= '0;
      end else if (coveredNow) begin
        bipAcc <= bipAcc ^ byteNow;
      end
      errPend <= (errPend && !parityNow) || errInsert;
    end
  end
endmodule

// File: rtl/plcp_frame_gen.sv
module plcp_frame_gen
  import plcp_gen_pkg::*;
#(
  parameter int CELL_BYTES = 53
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cellData,
  input  logic       cellSoc,
  input  logic       cellValid,
  output logic       cellReady,
  input  logic [7:0] userByte,
  input  logic [7:0] statusByte,
  input  logic [7:0] cycleByte,
  input  logic       errInsert,
  output logic [7:0] outData,
  output logic       outValid
);
  ctl_t ctl;
  logic errPend;

  plcp_gen_ctrl #(.CELL_BYTES(CELL_BYTES)) i_ctrl (
    .clk(clk), .rstN(rstN), .cellValid(cellValid), .cellSoc(cellSoc),
    .cellReady(cellReady), .ctl(ctl)
  );

  plcp_gen_dpath i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cellData(cellData),
    .userByte(userByte), .statusByte(statusByte), .cycleByte(cycleByte),
    .errInsert(errInsert), .outData(outData), .outValid(outValid),
    .errPend(errPend)
  );
endmodule

// File: rtl/plcp_frame_gen_chk.sv
module plcp_frame_gen_chk
  import plcp_gen_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cellSoc,
  input logic       cellValid,
  input logic       cellReady,
  input logic       errInsert,
  input logic [7:0] outData,
  input logic       outValid,
  input ctl_t       ctl,
  input logic       errPend
);
  a_r10_gap_no_output: assert property (@(posedge clk) disable iff (!rstN)
    (cellReady && !cellValid) |=> !outValid);

  a_r7_header_always_sent: assert property (@(posedge clk) disable iff (!rstN)
    !cellReady |=> outValid);

  a_r1_sync_first: assert property (@(posedge clk) disable iff (!rstN)
    (!cellReady && ctl.field == FLD_SYNC1) |=> (outValid && outData == 8'hF6));

  a_r1_sync_second: assert property (@(posedge clk) disable iff (!rstN)
    (!cellReady && ctl.field == FLD_SYNC2) |=> (outValid && outData == 8'h28));

  a_r9_no_soc_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (cellReady && ctl.cellFirst && cellValid && !cellSoc) |=> !outValid);

  a_r6_request_held: assert property (@(posedge clk) disable iff (!rstN)
    errInsert |=> errPend);

  a_r11_ready_low_in_reset: assert property (@(posedge clk)
    !rstN |-> !cellReady);
endmodule

bind plcp_frame_gen plcp_frame_gen_chk i_chk (.*);

// File: tb/test_plcp_frame_gen.sv
module test_plcp_frame_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CELLB      = 53;
  localparam int ROWB       = CELLB + 4;
  localparam int FRAMEB     = ROWB * 12;
  localparam int NFRAMES    = 3;
  localparam int TOTAL      = FRAMEB * NFRAMES;
  localparam int JUNK_AFTER = 30;
  localparam int WATCHDOG   = 20000;

  logic clk = 0, rstN = 0;
  logic [7:0] cellData = 0;
  logic cellSoc = 0, cellValid = 0, errInsert = 0;
  logic cellReady, outValid;
  logic [7:0] outData;
  logic [7:0] userByte = 8'hA5, statusByte = 8'hF7, cycleByte = 8'h3C;

  int checks = 0, fails = 0, rxCount = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plcp_frame_gen i_plcp_frame_gen (
    .clk(clk), .rstN(rstN), .cellData(cellData), .cellSoc(cellSoc),
    .cellValid(cellValid), .cellReady(cellReady), .userByte(userByte),
    .statusByte(statusByte), .cycleByte(cycleByte), .errInsert(errInsert),
    .outData(outData), .outValid(outValid)
  );

  function automatic logic [7:0] cellByte(int cellNo, int i);
    return 8'((cellNo * 7 + i * 3 + 1) & 255);
  endfunction

  function automatic logic [7:0] idByte(int r);
    case (r)
      0: return 8'h2C;  1: return 8'h29;  2: return 8'h25;  3: return 8'h20;
      4: return 8'h1C;  5: return 8'h19;  6: return 8'h15;  7: return 8'h10;
      8: return 8'h0D;  9: return 8'h08; 10: return 8'h04; default: return 8'h01;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h (byte %0d)", req, act, exp, rxCount);
    end
  endtask

  // Driver: 3 stray bytes, then 30 cells, 2 stray bytes, then more cells.
  initial begin
    int ptr = 0;
    int k2;
    bit fire, gapChk;
    wait (rstN);
    while (!done) begin
      @(negedge clk);
      cellValid = !((cyc % 13) == 5);
      k2 = ptr - 3;
      if (ptr < 3 || (k2 >= JUNK_AFTER * CELLB && k2 < JUNK_AFTER * CELLB + 2)) begin
        cellData = 8'hEE; cellSoc = 0;
      end else begin
        if (k2 >= JUNK_AFTER * CELLB) k2 = k2 - 2;
        cellData = cellByte(k2 / CELLB, k2 % CELLB);
        cellSoc  = (k2 % CELLB) == 0;
      end
      fire   = cellValid && cellReady;
      gapChk = !cellValid && cellReady;
      @(posedge clk); #1;
      if (fire) ptr++;
      if (gapChk) check(!outValid, "R10 gap", {7'b0, outValid}, 8'h00);
    end
  end

  // Error request once, inside frame 1 before its parity byte.
  initial begin
    wait (rxCount == FRAMEB + 60);
    @(negedge clk); errInsert = 1;
    @(negedge clk); errInsert = 0;
  end

  initial begin
    logic [7:0] bipAcc, bipPrev, exp;
    int f, r, c;
    bipAcc = 0; bipPrev = 0;
    repeat (3) @(posedge clk);
    #1;
    check(!outValid, "R11 reset outValid", {7'b0, outValid}, 8'h00);
    check(!cellReady, "R11 reset cellReady", {7'b0, cellReady}, 8'h00);
    @(negedge clk); rstN = 1;
    while (rxCount < TOTAL && cyc < WATCHDOG) begin
      @(posedge clk); #1;
      cyc++;
      if (outValid) begin
        f = rxCount / FRAMEB;
        r = (rxCount % FRAMEB) / ROWB;
        c = rxCount % ROWB;
        if (c == 0) begin exp = 8'hF6; check(outData == exp, "R1 sync1", outData, exp); end
        else if (c == 1) begin exp = 8'h28; check(outData == exp, "R1 sync2", outData, exp); end
        else if (c == 2) begin exp = idByte(r); check(outData == exp, "R2 row id", outData, exp); end
        else if (c == 3) begin
          case (r)
            6: exp = userByte;
            7: exp = bipPrev ^ {7'b0, f == 1};
            8: exp = {statusByte[7:3], 3'b000};
            11: exp = cycleByte;
            default: exp = 8'h00;
          endcase
          if (r == 7) check(outData == exp, "R5 R6 parity", outData, exp);
          else if (r == 8) check(outData == exp, "R4 status", outData, exp);
          else check(outData == exp, "R3 overhead", outData, exp);
        end else begin
          exp = cellByte(f * 12 + r, c - 4);
          check(outData == exp, "R8 R9 cell byte", outData, exp);
        end
        if (c >= 2) bipAcc = bipAcc ^ exp;
        rxCount++;
        if (rxCount % FRAMEB == 0) begin bipPrev = bipAcc; bipAcc = 0; end
      end
      if (rxCount < TOTAL) begin
        exp = {7'b0, (rxCount % ROWB) >= 4};
        check(cellReady == exp[0], "R7 ready", {7'b0, cellReady}, exp);
      end
    end
    if (cyc >= WATCHDOG) check(0, "watchdog", 8'(rxCount), 8'(TOTAL));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule